// File: doc/BRIEF.md
# Two-Byte Interprocessor Mailbox Channel

This block carries bytes between a host bus and a coprocessor (parasite) bus through two independent queues. One queue goes from host to parasite and the other from parasite to host. Each queue holds at most two bytes. A host-writable flag register selects how many bytes each queue uses. In one-byte mode a queue behaves as a single byte latch. In two-byte mode it reports data only when it holds a full pair. The same register enables an urgent interrupt request to the parasite and can hold the parasite processor in reset.

Each side sees "data ready" and "room left" status for the queue it reads or writes. A flag write can also re-initialise both queues without touching the flags; this is the soft reset. After any reset the parasite-to-host queue holds one filler byte, so that the interrupt request does not fire straight away in one-byte mode. The host can check whether a coprocessor is present by writing flags and reading them back: a mismatch means no coprocessor is attached.

Top module: `mbox_channel`

## Requirements
- R1: A hard reset (`rst` high at a clock edge) clears all six flags. It empties the host-to-parasite queue (`h2p_avail`=0, `h2p_nfull`=1). It leaves the parasite-to-host queue holding exactly one filler byte of value 0x00 (`p2h_avail`=1, `p2h_nfull`=0 while in one-byte mode). `p_nmi` and `p_cpu_rst` are 0.
- R2: A flag write (`ctl_wr`) with data bit 7 = 1 sets, and with bit 7 = 0 clears, every flag whose bit in data bits 5..0 is 1. Flags whose bit is 0 keep their value. The flag positions on `ctl_flags` are: bit 0 host-irq enable, bit 1 parasite-irq enable, bit 2 spare enable, bit 3 NMI enable (M), bit 4 two-byte mode (V), bit 5 parasite CPU reset (P). The result is visible on `ctl_flags` after the clock edge of the write.
- R3: `p_cpu_rst` equals the P flag (bit 5).
- R4: In one-byte mode (V=0), a queue reports data ready when it holds at least one byte. It reports room left only when it is empty. A write to a queue that has no room is dropped.
- R5: In two-byte mode (V=1), a queue reports data ready only when it holds two bytes. It reports room left while it holds fewer than two bytes. A third write is dropped.
- R6: Each read strobe on a non-empty queue removes one byte, oldest first. The read-data output shows the oldest byte held. A read on an empty queue has no effect.
- R7: A flag write with data bits 7 and 6 both 1 is a soft reset. It puts both queues into the R1 state at that clock edge, and any queue write in the same cycle is lost. Bits 5..0 of the same write are still applied as flag sets. The soft-reset bit is not stored and has no read-back position.
- R8: `p_nmi` is 1 exactly when M is set and either the parasite-to-host queue reports room left or the host-to-parasite queue reports data ready. Both statuses are evaluated in the current mode.
- R9: Activity on one queue never changes the contents or status of the other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset from host, synchronous, active high |
| ctl_wr | input | 1 | Flag register write strobe |
| ctl_wdata | input | 8 | Flag write data: bit 7 set/clear, bit 6 soft reset, bits 5..0 flag select |
| ctl_flags | output | 6 | Current flags for host read-back |
| h_wr | input | 1 | Host write strobe into host-to-parasite queue |
| h_wdata | input | 8 | Host write byte |
| p_rd | input | 1 | Parasite read strobe from host-to-parasite queue |
| p_rdata | output | 8 | Oldest byte of host-to-parasite queue |
| h2p_avail | output | 1 | Host-to-parasite data ready (parasite side) |
| h2p_nfull | output | 1 | Host-to-parasite room left (host side) |
| p_wr | input | 1 | Parasite write strobe into parasite-to-host queue |
| p_wdata | input | 8 | Parasite write byte |
| h_rd | input | 1 | Host read strobe from parasite-to-host queue |
| h_rdata | output | 8 | Oldest byte of parasite-to-host queue |
| p2h_avail | output | 1 | Parasite-to-host data ready (host side) |
| p2h_nfull | output | 1 | Parasite-to-host room left (parasite side) |
| p_nmi | output | 1 | Interrupt request to the parasite |
| p_cpu_rst | output | 1 | Parasite processor reset |

## Verification
Directed runs cover both modes. Single writes, pairs, and dropped third writes separate the one-byte thresholds from the two-byte thresholds. Reads on empty queues show that an underflow has no effect. Interrupt cases are built from the filler byte and from host data. The combination of a soft reset with flags already set separates it from a hard reset. The bench then issues random mixed traffic on both queues at once, with occasional mode flips, flag writes and soft resets. This exposes cross-talk between the queues, and errors in thresholds that change while a queue is partly filled.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned FLAG_W  = 6;
    localparam int unsigned BIT_SRST = 6;
    localparam int unsigned BIT_SET  = 7;

    typedef struct packed {
        logic cpu_hold;   // bit 5
        logic two_byte;   // bit 4
        logic nmi_en;     // bit 3
        logic spare_en;   // bit 2
        logic pirq_en;    // bit 1
        logic hirq_en;    // bit 0
    } flags_t;

    function automatic logic [1:0] path_cap(input logic two_byte);
        return two_byte ? 2'd2 : 2'd1;
    endfunction

    function automatic logic path_ready(input logic [1:0] cnt, input logic two_byte);
        return two_byte ? (cnt == 2'd2) : (cnt != 2'd0);
    endfunction

    function automatic logic path_room(input logic [1:0] cnt, input logic two_byte);
        return cnt < path_cap(two_byte);
    endfunction
endpackage

// File: rtl/mbox_path.sv
module mbox_path
    import mbox_pkg::*;
#(
    parameter int unsigned DW          = DATA_W,
    parameter int unsigned PRELOAD_CNT = 0,
    parameter logic [DW-1:0] PRELOAD_VAL = '0
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          two_byte,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic          avail,
    output logic          nfull
);
    localparam logic [1:0] PRE_CNT = 2'(PRELOAD_CNT);

    logic [1:0]    cnt, cnt_mid, cnt_nx;
    logic [DW-1:0] s0, s1, s0_nx, s1_nx;
    logic          push_ok, pop_ok;

    always_comb begin
        push_ok = wr && (cnt < path_cap(two_byte));
        pop_ok  = rd && (cnt != 2'd0);
        s0_nx   = pop_ok ? s1 : s0;
        s1_nx   = s1;
        cnt_mid = cnt - {1'b0, pop_ok};
        if (push_ok) begin
            if (cnt_mid == 2'd0) s0_nx = wdata;
            else                 s1_nx = wdata;
        end
        cnt_nx = cnt_mid + {1'b0, push_ok};
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= PRE_CNT;
            s0  <= PRELOAD_VAL;
            s1  <= '0;
        end else begin
            cnt <= cnt_nx;
            s0  <= s0_nx;
            s1  <= s1_nx;
        end
    end

    assign rdata = s0;
    assign avail = path_ready(cnt, two_byte);
    assign nfull = path_room(cnt, two_byte);

    p_no_overflow_r5: assert property (@(posedge clk) cnt <= 2'd2);

    p_reset_preload_r1: assert property (@(posedge clk)
        clr |=> (cnt == PRE_CNT && s0 == PRELOAD_VAL));

    p_full_write_dropped_r4: assert property (@(posedge clk) disable iff (clr)
        (wr && !rd && cnt >= path_cap(two_byte))
        |=> (cnt == $past(cnt) && s0 == $past(s0) && s1 == $past(s1)));

    p_pop_order_r6: assert property (@(posedge clk) disable iff (clr)
        (rd && !wr && cnt == 2'd2) |=> (cnt == 2'd1 && s0 == $past(s1)));

    p_empty_read_noop_r6: assert property (@(posedge clk) disable iff (clr)
        (rd && !wr && cnt == 2'd0) |=> (cnt == 2'd0));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [7:0]  wdata,
    output flags_t      flags,
    output logic        soft_rst
);
    flags_t sel;

    assign sel      = flags_t'(wdata[FLAG_W-1:0]);
    assign soft_rst = wr && wdata[BIT_SET] && wdata[BIT_SRST];

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (wr)
            flags <= wdata[BIT_SET] ? (flags | sel) : (flags & ~sel);
    end

    p_hard_clear_r1: assert property (@(posedge clk) rst |=> flags == '0);

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[BIT_SET]) |=> ((flags & $past(sel)) == $past(sel)));

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[BIT_SET]) |=> ((flags & $past(sel)) == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(flags));
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
    import mbox_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [FLAG_W-1:0] ctl_flags,
    input  logic              h_wr,
    input  logic [DW-1:0]     h_wdata,
    input  logic              p_rd,
    output logic [DW-1:0]     p_rdata,
    output logic              h2p_avail,
    output logic              h2p_nfull,
    input  logic              p_wr,
    input  logic [DW-1:0]     p_wdata,
    input  logic              h_rd,
    output logic [DW-1:0]     h_rdata,
    output logic              p2h_avail,
    output logic              p2h_nfull,
    output logic              p_nmi,
    output logic              p_cpu_rst
);
    flags_t flags;
    logic   soft_rst, path_clr;

    mbox_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .flags    (flags),
        .soft_rst (soft_rst)
    );

    assign path_clr = rst | soft_rst;

    mbox_path #(.DW(DW), .PRELOAD_CNT(0), .PRELOAD_VAL('0)) u_h2p (
        .clk      (clk),
        .clr      (path_clr),
        .two_byte (flags.two_byte),
        .wr       (h_wr),
        .wdata    (h_wdata),
        .rd       (p_rd),
        .rdata    (p_rdata),
        .avail    (h2p_avail),
        .nfull    (h2p_nfull)
    );

    mbox_path #(.DW(DW), .PRELOAD_CNT(1), .PRELOAD_VAL('0)) u_p2h (
        .clk      (clk),
        .clr      (path_clr),
        .two_byte (flags.two_byte),
        .wr       (p_wr),
        .wdata    (p_wdata),
        .rd       (h_rd),
        .rdata    (h_rdata),
        .avail    (p2h_avail),
        .nfull    (p2h_nfull)
    );

    assign ctl_flags = flags;
    assign p_cpu_rst = flags.cpu_hold;
    assign p_nmi     = flags.nmi_en && (p2h_nfull || h2p_avail);

    p_cpu_rst_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(p_cpu_rst) |-> $past(ctl_wr && ctl_wdata[BIT_SET] && ctl_wdata[5]));

    p_soft_reset_empties_r7: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!h2p_avail && h2p_nfull));

    p_soft_reset_keeps_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && ctl_wdata[5:0] == '0) |=> $stable(ctl_flags));

    p_nmi_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl_flags[3] |-> !p_nmi);
endmodule

// File: tb/test_mbox_channel.sv
`timescale 1ns/1ps
module test_mbox_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [5:0] ctl_flags;
    logic       h_wr = 1'b0, p_rd = 1'b0, p_wr = 1'b0, h_rd = 1'b0;
    logic [7:0] h_wdata = '0, p_wdata = '0;
    logic [7:0] p_rdata, h_rdata;
    logic       h2p_avail, h2p_nfull, p2h_avail, p2h_nfull, p_nmi, p_cpu_rst;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [5:0] m_flags;
    logic [7:0] hq0, hq1, pq0, pq1;
    int         hc, pc;

    always #2 clk = ~clk;

    mbox_channel i_mbox_channel (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_flags(ctl_flags), .h_wr(h_wr), .h_wdata(h_wdata), .p_rd(p_rd),
        .p_rdata(p_rdata), .h2p_avail(h2p_avail), .h2p_nfull(h2p_nfull),
        .p_wr(p_wr), .p_wdata(p_wdata), .h_rd(h_rd), .h_rdata(h_rdata),
        .p2h_avail(p2h_avail), .p2h_nfull(p2h_nfull), .p_nmi(p_nmi),
        .p_cpu_rst(p_cpu_rst)
    );

    function automatic int cap_of(input logic v);
        return v ? 2 : 1;
    endfunction
    function automatic logic ready_of(input int c, input logic v);
        return v ? (c == 2) : (c != 0);
    endfunction
    function automatic logic room_of(input int c, input logic v);
        return c < cap_of(v);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic path_step(inout logic [7:0] q0, inout logic [7:0] q1, inout int c,
                             input logic wr, input logic [7:0] d, input logic rd,
                             input logic v, input logic clr, input int pre);
        logic push, pop;
        if (clr) begin
            c = pre; q0 = '0; q1 = '0;
            return;
        end
        push = wr && (c < cap_of(v));
        pop  = rd && (c > 0);
        if (pop) begin q0 = q1; c--; end
        if (push) begin
            if (c == 0) q0 = d; else q1 = d;
            c++;
        end
    endtask

    task automatic model_step();
        logic srst, v;
        srst = ctl_wr && ctl_wdata[7] && ctl_wdata[6];
        v    = m_flags[4];
        path_step(hq0, hq1, hc, h_wr, h_wdata, p_rd, v, rst || srst, 0);
        path_step(pq0, pq1, pc, p_wr, p_wdata, h_rd, v, rst || srst, 1);
        if (rst) m_flags = '0;
        else if (ctl_wr)
            m_flags = ctl_wdata[7] ? (m_flags | ctl_wdata[5:0]) : (m_flags & ~ctl_wdata[5:0]);
    endtask

    task automatic compare();
        logic v;
        string st;
        v  = m_flags[4];
        st = v ? "R5" : "R4";
        chk("R2 flags", ctl_flags, m_flags);
        chk("R3 cpu reset", p_cpu_rst, m_flags[5]);
        chk({st, " h2p ready"}, h2p_avail, ready_of(hc, v));
        chk({st, " h2p room"}, h2p_nfull, room_of(hc, v));
        chk({st, " p2h ready (R9)"}, p2h_avail, ready_of(pc, v));
        chk({st, " p2h room (R9)"}, p2h_nfull, room_of(pc, v));
        chk("R8 nmi", p_nmi, m_flags[3] && (room_of(pc, v) || ready_of(hc, v)));
        if (hc > 0) chk("R6 p_rdata", p_rdata, hq0);
        if (pc > 0) chk("R6 h_rdata", h_rdata, pq0);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        compare();
        ctl_wr = 0; h_wr = 0; p_rd = 0; p_wr = 0; h_rd = 0;
    endtask

    task automatic ctl(input logic [7:0] d);
        ctl_wr = 1; ctl_wdata = d; tick();
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_flags = '0; hq0 = '0; hq1 = '0; pq0 = '0; pq1 = '0; hc = 0; pc = 1;
        #1;
        rst = 1; tick(); rst = 1; tick(); rst = 0;
        // R1 reset state
        chk("R1 h2p_avail", h2p_avail, 0);
        chk("R1 h2p_nfull", h2p_nfull, 1);
        chk("R1 p2h_avail", p2h_avail, 1);
        chk("R1 p2h_nfull", p2h_nfull, 0);
        chk("R1 flags", ctl_flags, 0);
        chk("R1 nmi", p_nmi, 0);
        chk("R1 filler", h_rdata, 8'h00);

        // R2 set/clear
        ctl(8'hBF);
        chk("R2 set all", ctl_flags, 6'h3F);
        chk("R3 held", p_cpu_rst, 1);
        ctl(8'h21);
        chk("R2 clear some", ctl_flags, 6'h1E);
        chk("R3 released", p_cpu_rst, 0);
        ctl(8'h1E);
        chk("R2 clear rest", ctl_flags, 6'h00);

        // R4 one-byte mode, dropped write, R9 isolation
        h_wr = 1; h_wdata = 8'h11; tick();
        chk("R4 one byte ready", h2p_avail, 1);
        chk("R4 no room", h2p_nfull, 0);
        chk("R9 p2h untouched", p2h_avail, 1);
        h_wr = 1; h_wdata = 8'h22; tick();
        chk("R4 head kept", p_rdata, 8'h11);
        p_rd = 1; tick();
        chk("R4 dropped write absent", h2p_avail, 0);
        chk("R4 room after pop", h2p_nfull, 1);

        // R5 two-byte mode
        ctl(8'h90);
        h_wr = 1; h_wdata = 8'h33; tick();
        chk("R5 one of two not ready", h2p_avail, 0);
        chk("R5 room with one", h2p_nfull, 1);
        h_wr = 1; h_wdata = 8'h44; tick();
        chk("R5 pair ready", h2p_avail, 1);
        chk("R5 full", h2p_nfull, 0);
        h_wr = 1; h_wdata = 8'h55; tick();
        chk("R6 oldest first", p_rdata, 8'h33);
        p_rd = 1; tick();
        chk("R6 second byte", p_rdata, 8'h44);
        chk("R5 not ready after pop", h2p_avail, 0);
        p_rd = 1; tick();
        p_rd = 1; tick();
        chk("R6 empty read no effect", h2p_nfull, 1);

        // R8 interrupt
        ctl(8'h88);
        chk("R8 nmi from p2h room", p_nmi, 1);
        ctl(8'h10);
        chk("R8 nmi quiet one-byte", p_nmi, 0);
        h_wr = 1; h_wdata = 8'h66; tick();
        chk("R8 nmi from h2p data", p_nmi, 1);

        // R7 soft reset keeps flags
        h_rd = 1; tick();
        p_wr = 1; p_wdata = 8'h77; tick();
        ctl(8'hC0);
        chk("R7 flags kept", ctl_flags, 6'h08);
        chk("R7 h2p emptied", h2p_avail, 0);
        chk("R7 filler back", h_rdata, 8'h00);
        chk("R7 p2h one byte", p2h_nfull, 0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            h_wr = r[0]; p_rd = r[1]; p_wr = r[2]; h_rd = r[3];
            h_wdata = 8'($urandom()); p_wdata = 8'($urandom());
            if (r[8:5] == 0) begin
                ctl_wr = 1;
                ctl_wdata = 8'($urandom());
                if (r[13:9] != 0) ctl_wdata[6] = 0;
            end
            rst = (r[20:12] == 0);
            tick();
            rst = 0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
    end
endmodule